// File: doc/BRIEF.md
# Per-Drive Perpendicular Write Mode Selector

This block stores the perpendicular-recording settings of a floppy disk controller and turns them, for whichever drive is selected, into the parameters that a write data operation needs. Software programs it with a command byte that carries a global two-bit recording mode, four per-drive perpendicular marks and an overwrite qualifier that guards those marks. A conventional drive and a perpendicular drive can therefore share one controller with no reprogramming between accesses.

For the selected drive the block reports five things. The first is the effective recording mode. The second is the length of the Gap2 format field and the third is how many of those Gap2 bytes the write operation must write itself. The fourth is the write pre-compensation to apply. The fifth is a flag that tells the write-gate logic to open inside Gap2 rather than at the start of the sync field. All outputs are registered. They freeze while a write is in progress, so the parameters cannot change in the middle of a sector. A soft reset clears only the global mode. A hard reset clears the global mode and the per-drive marks.

Top module: `perp_write_sel`

## Requirements
- R1: The global field of the command byte is bit 1 (G) and bit 0 (W). W=1, G=0 selects perpendicular at 500 Kbps (mode_o = 1). W=1, G=1 selects perpendicular at 1 Mbps (mode_o = 2). W=0, G=0 is conventional (mode_o = 0) unless R5 applies.
- R2: gap2_len_o is 41 in the 1 Mbps perpendicular mode (mode_o = 2) and 22 in every other mode.
- R3: gap2_wr_o is 38 when mode_o = 2, 19 when mode_o = 1, and 0 when mode_o = 0 or 3.
- R4: The reserved code W=0, G=1 behaves as conventional. While W or G is 1, the per-drive marks have no effect on any output.
- R5: The per-drive marks are command bits 5:2, with bit 2 for drive 0 and bit 5 for drive 3. When W=G=0 and the selected drive's mark is set, rate code 00 gives mode_o = 1, rate code 11 gives mode_o = 2, and codes 01 and 10 give mode_o = 3 (perpendicular drive, 22-byte field, nothing written).
- R6: precomp_o is 0 whenever mode_o is not 0. In conventional mode it equals the precomp_i value that was sampled.
- R7: A command write changes the per-drive marks only when bit 7 (overwrite) is 1. Otherwise the marks keep their values, while G and W are still loaded.
- R8: A soft reset clears G and W and leaves the per-drive marks unchanged.
- R9: A hard reset strobe, or rst, clears G, W and all per-drive marks. After rst the outputs read mode 0, length 22, 0 bytes written, precomp 0 and no early gate.
- R10: early_wgate_o is 1 exactly when gap2_wr_o is non-zero.
- R11: The outputs show the decode of the inputs and settings sampled at the previous clock edge. A command therefore appears two edges after its strobe. While wip_i is 1 the outputs hold their values.
- R12: A command strobe in the same cycle as a soft reset is discarded. G and W end at 0 and the marks are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | One-cycle strobe: cmd_byte_i is a mode command |
| cmd_byte_i | input | 8 | Command byte: bit 7 overwrite, bits 5:2 drive marks, bit 1 G, bit 0 W |
| soft_rst_i | input | 1 | Soft reset strobe (clears G and W) |
| hard_rst_i | input | 1 | Hard reset strobe (clears all settings) |
| drive_sel_i | input | DSEL_W (2) | Drive being accessed |
| rate_i | input | 2 | Programmed data rate code |
| precomp_i | input | PC_W (3) | Programmed write pre-compensation code |
| wip_i | input | 1 | Write in progress: hold outputs |
| mode_o | output | 2 | Effective mode: 0 conv, 1 perp 500K, 2 perp 1M, 3 perp drive at other rate |
| gap2_len_o | output | 6 | Gap2 format field length in bytes |
| gap2_wr_o | output | 6 | Gap2 bytes written by the write data operation |
| precomp_o | output | PC_W (3) | Effective pre-compensation code |
| early_wgate_o | output | 1 | Assert write gate inside Gap2 |

## Verification
On every cycle the assertions check that the output fields agree with one another: the length against the mode, the written bytes against the early-gate flag, and zero pre-compensation in any non-conventional mode. They also check that the outputs freeze under wip_i, that the marks stay put without the overwrite bit or during a soft reset, and that a hard reset clears everything. Only the bench's scenarios can show that the right drive's mark is chosen and that the data-rate codes map correctly. The same holds for the reserved global code masking the marks, and for a command that coincides with a soft reset being dropped as a whole. The bench shows these by sweeping every command pattern against every drive and rate, followed by directed sequences.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  localparam int CMD_W   = 8;
  localparam int LEN_W   = 6;
  localparam int RATE_W  = 2;

  // command byte bit positions
  localparam int OW_BIT  = 7;
  localparam int MARK_LO = 2;
  localparam int G_BIT   = 1;
  localparam int W_BIT   = 0;

  // data-rate codes with a defined perpendicular Gap2 write amount
  localparam logic [RATE_W-1:0] RATE_500K = 2'b00;
  localparam logic [RATE_W-1:0] RATE_1M   = 2'b11;

  // Gap2 byte counts
  localparam logic [LEN_W-1:0] LEN_STD = 6'd22;
  localparam logic [LEN_W-1:0] LEN_1M  = 6'd41;
  localparam logic [LEN_W-1:0] WR_500K = 6'd19;
  localparam logic [LEN_W-1:0] WR_1M   = 6'd38;

  typedef enum logic [1:0] {
    WM_CONV   = 2'd0,
    WM_P500   = 2'd1,
    WM_P1M    = 2'd2,
    WM_POTHER = 2'd3
  } wmode_e;

  typedef struct packed {
    wmode_e           mode;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] wr;
    logic             early;
  } wsel_t;

  localparam wsel_t WSEL_IDLE = '{mode: WM_CONV, len: LEN_STD, wr: '0, early: 1'b0};

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pmode_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid_i,
  input  logic [CMD_W-1:0]      cmd_byte_i,
  input  logic                  soft_rst_i,
  input  logic                  hard_rst_i,
  output logic                  gap_o,
  output logic                  wgate_o,
  output logic [NUM_DRIVES-1:0] marks_o
);

  logic                  gap_q, wgate_q;
  logic [NUM_DRIVES-1:0] marks_q;

  always_ff @(posedge clk) begin
    if (rst || hard_rst_i) begin
      gap_q   <= 1'b0;
      wgate_q <= 1'b0;
      marks_q <= '0;
    end else if (soft_rst_i) begin
      // soft reset wins over a coincident command; marks survive
      gap_q   <= 1'b0;
      wgate_q <= 1'b0;
    end else if (cmd_valid_i) begin
      gap_q   <= cmd_byte_i[G_BIT];
      wgate_q <= cmd_byte_i[W_BIT];
      if (cmd_byte_i[OW_BIT]) begin
        marks_q <= cmd_byte_i[MARK_LO +: NUM_DRIVES];
      end
    end
  end

  assign gap_o   = gap_q;
  assign wgate_o = wgate_q;
  assign marks_o = marks_q;

  p_no_ow_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && !cmd_byte_i[OW_BIT] && !soft_rst_i && !hard_rst_i) |=> $stable(marks_q));

  p_soft_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_i && !hard_rst_i) |=> (!gap_q && !wgate_q && $stable(marks_q)));

  p_hard_clear_r9: assert property (@(posedge clk) disable iff (rst)
    hard_rst_i |=> (!gap_q && !wgate_q && marks_q == '0));

  p_soft_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_i && cmd_valid_i && !hard_rst_i) |=> (!gap_q && !wgate_q));

endmodule

// File: rtl/pm_drive_decode.sv
module pm_drive_decode
  import pmode_pkg::*;
#(
  parameter int PC_W = 3
) (
  input  logic              gap_i,
  input  logic              wgate_i,
  input  logic              mark_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [PC_W-1:0]   precomp_i,
  output wsel_t             sel_o,
  output logic [PC_W-1:0]   pc_o
);

  wmode_e mode;

  always_comb begin
    if (wgate_i) begin
      mode = gap_i ? WM_P1M : WM_P500;
    end else if (gap_i) begin
      mode = WM_CONV;               // reserved code, marks masked
    end else if (mark_i) begin
      unique case (rate_i)
        RATE_500K: mode = WM_P500;
        RATE_1M:   mode = WM_P1M;
        default:   mode = WM_POTHER;
      endcase
    end else begin
      mode = WM_CONV;
    end
  end

  always_comb begin
    sel_o.mode = mode;
    sel_o.len  = (mode == WM_P1M) ? LEN_1M : LEN_STD;
    unique case (mode)
      WM_P1M:  sel_o.wr = WR_1M;
      WM_P500: sel_o.wr = WR_500K;
      default: sel_o.wr = '0;
    endcase
    sel_o.early = (mode == WM_P1M) || (mode == WM_P500);
    pc_o        = (mode == WM_CONV) ? precomp_i : '0;
  end

endmodule

// File: rtl/pm_out_stage.sv
module pm_out_stage
  import pmode_pkg::*;
#(
  parameter int PC_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_i,
  input  wsel_t           sel_i,
  input  logic [PC_W-1:0] pc_i,
  output wsel_t           sel_o,
  output logic [PC_W-1:0] pc_o
);

  wsel_t           sel_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= WSEL_IDLE;
      pc_q  <= '0;
    end else if (!hold_i) begin
      sel_q <= sel_i;
      pc_q  <= pc_i;
    end
  end

  assign sel_o = sel_q;
  assign pc_o  = pc_q;

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> ($stable(sel_q) && $stable(pc_q)));

  p_load_r11: assert property (@(posedge clk) disable iff (rst)
    !hold_i |=> (sel_q == $past(sel_i) && pc_q == $past(pc_i)));

endmodule

// File: rtl/perp_write_sel.sv
module perp_write_sel
  import pmode_pkg::*;
#(
  parameter  int NUM_DRIVES = 4,   // 1..4, one mark bit each in bits 5:2
  parameter  int PC_W       = 3,
  localparam int DSEL_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_byte_i,
  input  logic              soft_rst_i,
  input  logic              hard_rst_i,
  input  logic [DSEL_W-1:0] drive_sel_i,
  input  logic [1:0]        rate_i,
  input  logic [PC_W-1:0]   precomp_i,
  input  logic              wip_i,
  output logic [1:0]        mode_o,
  output logic [5:0]        gap2_len_o,
  output logic [5:0]        gap2_wr_o,
  output logic [PC_W-1:0]   precomp_o,
  output logic              early_wgate_o
);

  localparam int SLOTS = 1 << DSEL_W;

  logic                  cfg_gap, cfg_wgate;
  logic [NUM_DRIVES-1:0] cfg_marks;
  logic                  unused_cmd_bit6;

  assign unused_cmd_bit6 = cmd_byte_i[6];

  pm_cfg_regs #(.NUM_DRIVES(NUM_DRIVES)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_byte_i  (cmd_byte_i),
    .soft_rst_i  (soft_rst_i),
    .hard_rst_i  (hard_rst_i),
    .gap_o       (cfg_gap),
    .wgate_o     (cfg_wgate),
    .marks_o     (cfg_marks)
  );

  wsel_t           dec_sel [SLOTS];
  logic [PC_W-1:0] dec_pc  [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic mark;
    if (i < NUM_DRIVES) begin : g_real
      assign mark = cfg_marks[i];
    end else begin : g_pad
      assign mark = 1'b0;
    end
    pm_drive_decode #(.PC_W(PC_W)) u_dec (
      .gap_i     (cfg_gap),
      .wgate_i   (cfg_wgate),
      .mark_i    (mark),
      .rate_i    (rate_i),
      .precomp_i (precomp_i),
      .sel_o     (dec_sel[i]),
      .pc_o      (dec_pc[i])
    );
  end

  wsel_t           cur_sel, out_sel;
  logic [PC_W-1:0] cur_pc;

  assign cur_sel = dec_sel[drive_sel_i];
  assign cur_pc  = dec_pc[drive_sel_i];

  pm_out_stage #(.PC_W(PC_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .hold_i (wip_i),
    .sel_i  (cur_sel),
    .pc_i   (cur_pc),
    .sel_o  (out_sel),
    .pc_o   (precomp_o)
  );

  assign mode_o        = out_sel.mode;
  assign gap2_len_o    = out_sel.len;
  assign gap2_wr_o     = out_sel.wr;
  assign early_wgate_o = out_sel.early;

  p_len_r2: assert property (@(posedge clk) disable iff (rst)
    gap2_len_o == ((mode_o == 2'd2) ? 6'd41 : 6'd22));

  p_wr_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> (gap2_wr_o == 6'd19));

  p_precomp_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd0) |-> (precomp_o == '0));

  p_precomp_pass_r6: assert property (@(posedge clk) disable iff (rst)
    !wip_i |=> (mode_o != 2'd0 || precomp_o == $past(precomp_i)));

  p_early_r10: assert property (@(posedge clk) disable iff (rst)
    early_wgate_o == (gap2_wr_o != 6'd0));

endmodule

// File: tb/perp_write_sel_tb.sv
module perp_write_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_byte_i = '0;
  logic       soft_rst_i = 1'b0;
  logic       hard_rst_i = 1'b0;
  logic [1:0] drive_sel_i = '0;
  logic [1:0] rate_i = '0;
  logic [2:0] precomp_i = '0;
  logic       wip_i = 1'b0;
  logic [1:0] mode_o;
  logic [5:0] gap2_len_o, gap2_wr_o;
  logic [2:0] precomp_o;
  logic       early_wgate_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // bench model of the settings
  bit       m_g, m_w;
  bit [3:0] m_marks;

  always #5 clk = ~clk;

  perp_write_sel dut_i (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_byte_i(cmd_byte_i),
    .soft_rst_i(soft_rst_i), .hard_rst_i(hard_rst_i), .drive_sel_i(drive_sel_i),
    .rate_i(rate_i), .precomp_i(precomp_i), .wip_i(wip_i), .mode_o(mode_o),
    .gap2_len_o(gap2_len_o), .gap2_wr_o(gap2_wr_o), .precomp_o(precomp_o),
    .early_wgate_o(early_wgate_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int e_mode(bit g, bit w, bit mk, int r);
    if (w) return g ? 2 : 1;
    if (g) return 0;
    if (mk) return (r == 0) ? 1 : (r == 3) ? 2 : 3;
    return 0;
  endfunction

  // compare all outputs with expectations for the current model and inputs
  task automatic check_all(input int ds, input int rt, input int pc);
    int    m   = e_mode(m_g, m_w, m_marks[ds], rt);
    int    wr  = (m == 2) ? 38 : (m == 1) ? 19 : 0;
    string mt  = m_w ? "R1" : m_g ? "R4" : m_marks[ds] ? "R5" : "R1";
    chk(mt,    mode_o, m);
    chk("R2",  gap2_len_o, (m == 2) ? 41 : 22);
    chk("R3",  gap2_wr_o, wr);
    chk("R6",  precomp_o, (m == 0) ? pc : 0);
    chk("R10", early_wgate_o, (wr != 0) ? 1 : 0);
  endtask

  task automatic send_cmd(input bit ow, input bit [3:0] mk, input bit g, input bit w);
    @(negedge clk);
    cmd_byte_i  = {ow, 1'b0, mk, g, w};
    cmd_valid_i = 1'b1;
    m_g = g; m_w = w;
    if (ow) m_marks = mk;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  // set select inputs now (at a negedge), check one edge later
  task automatic probe(input int ds, input int rt, input int pc);
    drive_sel_i = 2'(ds); rate_i = 2'(rt); precomp_i = 3'(pc);
    @(negedge clk);
    check_all(ds, rt, pc);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    m_g = 0; m_w = 0; m_marks = '0;
    precomp_i = 3'd5;
    repeat (3) @(negedge clk);
    // R9: state straight out of rst
    chk("R9", mode_o, 0);
    chk("R9", gap2_len_o, 22);
    chk("R9", gap2_wr_o, 0);
    chk("R9", precomp_o, 0);
    chk("R9", early_wgate_o, 0);
    rst = 1'b0;

    // exhaustive sweep: every command pattern, then every drive and rate
    for (int ow = 0; ow < 2; ow++)
      for (int mk = 0; mk < 16; mk++)
        for (int g = 0; g < 2; g++)
          for (int w = 0; w < 2; w++) begin
            send_cmd(ow[0], mk[3:0], g[0], w[0]);
            for (int ds = 0; ds < 4; ds++)
              for (int rt = 0; rt < 4; rt++)
                probe(ds, rt, (ds * 3 + rt + 1) % 8);
          end

    // R7: no overwrite bit -> marks kept, G/W still loaded
    send_cmd(1'b1, 4'b0110, 1'b0, 1'b0);
    send_cmd(1'b0, 4'b1001, 1'b0, 1'b0);
    drive_sel_i = 2'd1; rate_i = 2'd0; precomp_i = 3'd4;
    @(negedge clk);
    chk("R7", mode_o, 1);
    drive_sel_i = 2'd0;
    @(negedge clk);
    chk("R7", mode_o, 0);
    chk("R7", precomp_o, 4);

    // R8: soft reset clears global mode only
    send_cmd(1'b1, 4'b0001, 1'b1, 1'b1);
    probe(2, 0, 3);                      // global 1M on unmarked drive
    @(negedge clk); soft_rst_i = 1'b1;
    @(negedge clk); soft_rst_i = 1'b0; m_g = 0; m_w = 0;
    drive_sel_i = 2'd0; rate_i = 2'd3;
    @(negedge clk);
    chk("R8", mode_o, 2);                // mark of drive 0 survived
    drive_sel_i = 2'd2;
    @(negedge clk);
    chk("R8", mode_o, 0);
    chk("R8", precomp_o, 3);

    // R12: command coinciding with soft reset is dropped
    send_cmd(1'b1, 4'b0100, 1'b0, 1'b1); // marks=0100, perp 500 global
    @(negedge clk);
    cmd_byte_i = {1'b1, 1'b0, 4'b0010, 1'b1, 1'b1};
    cmd_valid_i = 1'b1; soft_rst_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0; soft_rst_i = 1'b0; m_g = 0; m_w = 0;
    drive_sel_i = 2'd2; rate_i = 2'd0;
    @(negedge clk);
    chk("R12", mode_o, 1);
    drive_sel_i = 2'd1;
    @(negedge clk);
    chk("R12", mode_o, 0);

    // R9: hard reset strobe clears the marks too
    @(negedge clk); hard_rst_i = 1'b1;
    @(negedge clk); hard_rst_i = 1'b0; m_marks = '0;
    drive_sel_i = 2'd2; rate_i = 2'd3; precomp_i = 3'd6;
    @(negedge clk);
    chk("R9", mode_o, 0);
    chk("R9", precomp_o, 6);

    // R11: outputs hold under wip_i, then catch up in one edge
    send_cmd(1'b1, 4'b1000, 1'b0, 1'b0);
    probe(3, 3, 2);                      // perp 1M on drive 3
    wip_i = 1'b1;
    drive_sel_i = 2'd0; rate_i = 2'd1; precomp_i = 3'd7;
    send_cmd(1'b1, 4'b0000, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R11", mode_o, 2);
    chk("R11", gap2_len_o, 41);
    chk("R11", gap2_wr_o, 38);
    chk("R11", precomp_o, 0);
    wip_i = 1'b0;
    @(negedge clk);
    chk("R11", mode_o, 0);
    chk("R11", precomp_o, 7);

    // R11: command latency is two edges from the strobe
    @(negedge clk);
    cmd_byte_i = 8'b0000_0001; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk("R11", mode_o, 0);               // settings updated, outputs not yet
    @(negedge clk);
    chk("R11", mode_o, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule